// File: doc/BRIEF.md
# Packed 16-bit Multiply-Accumulate Execute Unit

This unit executes one non-standard instruction in the execute stage of a small 32-bit pipeline. The instruction uses the ordinary register-register word layout with its 7-bit major opcode set to all ones. The unit takes the low halfword of each of two source registers as signed 16-bit numbers and multiplies them. It adds the product to the value already held in the destination register. The result goes back to that same destination, so the destination register serves as the accumulator.

The unit decodes the three register indices straight from the incoming word, so the register file can fetch the two sources and the old destination value. It receives those three values in the same cycle as the word. The match flag, write enable, destination index and result are registered, so they appear one clock later. A new word can be accepted every clock. A small state register records what the output slot holds: nothing, a result to commit, or a result whose write is suppressed.

Slot states and transitions: `SLOT_IDLE` (no instruction recognised), `SLOT_COMMIT` (recognised, destination non-zero) and `SLOT_DISCARD` (recognised, destination index zero). On every clock the next state depends only on the word at the input. A non-matching word leads to `SLOT_IDLE`. A matching word with destination zero leads to `SLOT_DISCARD`. Any other matching word leads to `SLOT_COMMIT`. Every state can reach every other state in one cycle. Reset forces `SLOT_IDLE`.

Top module: `mac_exec_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, hit_o and wr_en_o are 0, and wr_idx_o and wr_data_o are 0.
- R2: hit_o is 1 in the cycle after a clock edge if instr_i[6:0] was 7'b1111111 at that edge. Any other opcode value, including 7'b1111110 and 7'b0110011, gives hit_o = 0.
- R3: The fields are decoded as follows: destination index = instr_i[11:7], first source index = instr_i[19:15], second source index = instr_i[24:20]. For a recognised word, wr_idx_o one cycle later equals the destination field.
- R4: For a recognised word, wr_data_o one cycle later equals acc_i + sext(src_a_i[15:0]) * sext(src_b_i[15:0]), taken modulo 2^32.
- R5: Bits [31:16] of src_a_i and src_b_i have no effect on the result.
- R6: The sum wraps modulo 2^32 with no saturation. For example, 0x7FFFFFFF + 1*1 gives 0x80000000, and 0xFFFFFFF0 + 4*4 gives 0.
- R7: For a non-matching word, wr_en_o = 0, wr_idx_o = 0 and wr_data_o = 0 one cycle later.
- R8: For a recognised word with destination field 0, hit_o = 1, wr_en_o = 0, wr_idx_o = 0, and wr_data_o still carries the computed sum.
- R9: Bits [14:12] and [31:25] of the word do not affect matching or the result.
- R10: The read-select outputs src_a_sel_o, src_b_sel_o and acc_sel_o follow the current word combinationally. For 0x00C5857F they are 11, 12 and 10.
- R11: With words issued back to back, every cycle produces the result of the word from the cycle before, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word in the execute stage |
| src_a_i | input | 32 | Value of the first source register |
| src_b_i | input | 32 | Value of the second source register |
| acc_i | input | 32 | Old value of the destination register |
| src_a_sel_o | output | 5 | Register file read index for the first source |
| src_b_sel_o | output | 5 | Register file read index for the second source |
| acc_sel_o | output | 5 | Register file read index for the accumulator |
| hit_o | output | 1 | Registered: the previous word was this instruction |
| wr_en_o | output | 1 | Registered write enable toward the register file |
| wr_idx_o | output | 5 | Registered destination index |
| wr_data_o | output | 32 | Registered accumulate result |

## Verification
The hardest case to reach is a change of slot state on every single cycle. Examples are a commit followed directly by a discard, or a discard followed by an unrecognised word. Each of these must leave clean zeros or a correct sum with no leftover from the word before. The stimulus issues long unbroken runs that alternate recognised words, destination-zero words and foreign opcodes. The operands are chosen near the extremes of the signed halfword range, and some have garbage in their upper halves, so wrap, sign extension and field isolation are all exercised in consecutive cycles.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int INSTR_W = 32;
    localparam logic [6:0] OPC_MAC = 7'b1111111;

    // register-register word layout; field order is fixed by the encoding
    typedef struct packed {
        logic [6:0] hi_fn;
        logic [4:0] sel_b;
        logic [4:0] sel_a;
        logic [2:0] lo_fn;
        logic [4:0] dst;
        logic [6:0] opc;
    } rr_word_t;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_COMMIT  = 2'd1,
        SLOT_DISCARD = 2'd2
    } slot_e;
endpackage

// File: rtl/mac_field_decode.sv
module mac_field_decode
    import mac_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic               is_mac_o,
    output logic [IDX_W-1:0]   dst_o,
    output logic [IDX_W-1:0]   sel_a_o,
    output logic [IDX_W-1:0]   sel_b_o
);
    rr_word_t word;
    logic     unused_fn;

    always_comb begin
        word     = rr_word_t'(instr_i);
        is_mac_o = (word.opc == OPC_MAC);
        dst_o    = IDX_W'(word.dst);
        sel_a_o  = IDX_W'(word.sel_a);
        sel_b_o  = IDX_W'(word.sel_b);
    end

    // function fields take no part in this instruction
    assign unused_fn = ^{word.lo_fn, word.hi_fn};
endmodule

// File: rtl/mac_product_sum.sv
module mac_product_sum #(
    parameter int DATA_W = 32,
    parameter int OPND_W = 16
) (
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic [DATA_W-1:0] sum_o
);
    localparam int HI_W = DATA_W - OPND_W;

    logic signed [OPND_W-1:0] half_a, half_b;
    logic signed [DATA_W-1:0] wide_a, wide_b, prod;
    logic                     unused_hi;

    always_comb begin
        half_a = src_a_i[OPND_W-1:0];
        half_b = src_b_i[OPND_W-1:0];
        wide_a = DATA_W'(half_a);
        wide_b = DATA_W'(half_b);
        prod   = wide_a * wide_b;
        sum_o  = acc_i + prod;
    end

    generate
        if (HI_W > 0) begin : g_hi
            assign unused_hi = ^{src_a_i[DATA_W-1:OPND_W], src_b_i[DATA_W-1:OPND_W]};
        end else begin : g_nohi
            assign unused_hi = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mac_commit_stage.sv
module mac_commit_stage
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_mac_i,
    input  logic [IDX_W-1:0]  dst_i,
    input  logic [DATA_W-1:0] sum_i,
    output logic              hit_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o
);
    slot_e             state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sum_q;

    always_comb begin
        if (!is_mac_i)
            state_d = SLOT_IDLE;
        else if (dst_i == '0)
            state_d = SLOT_DISCARD;
        else
            state_d = SLOT_COMMIT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sum_q <= '0;
        end else begin
            idx_q <= is_mac_i ? dst_i : '0;
            sum_q <= is_mac_i ? sum_i : '0;
        end
    end

    // outputs
    always_comb begin
        hit_o     = 1'b0;
        wr_en_o   = 1'b0;
        wr_idx_o  = '0;
        wr_data_o = '0;
        unique case (state_q)
            SLOT_IDLE: ;
            SLOT_COMMIT: begin
                hit_o     = 1'b1;
                wr_en_o   = 1'b1;
                wr_idx_o  = idx_q;
                wr_data_o = sum_q;
            end
            SLOT_DISCARD: begin
                hit_o     = 1'b1;
                wr_data_o = sum_q;
            end
            default: ;
        endcase
    end

    a_r2_match_hits: assert property (@(posedge clk) disable iff (!rst_n)
        is_mac_i |=> hit_o);
    a_r3_dest_follows: assert property (@(posedge clk) disable iff (!rst_n)
        is_mac_i |=> (wr_idx_o == $past(dst_i)));
    a_r4_sum_follows: assert property (@(posedge clk) disable iff (!rst_n)
        is_mac_i |=> (wr_data_o == $past(sum_i)));
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (!wr_en_o && wr_idx_o == '0 && wr_data_o == '0));
    a_r8_zero_dest_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o != '0 && hit_o));
endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OPND_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  src_a_i,
    input  logic [DATA_W-1:0]  src_b_i,
    input  logic [DATA_W-1:0]  acc_i,
    output logic [IDX_W-1:0]   src_a_sel_o,
    output logic [IDX_W-1:0]   src_b_sel_o,
    output logic [IDX_W-1:0]   acc_sel_o,
    output logic               hit_o,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_idx_o,
    output logic [DATA_W-1:0]  wr_data_o
);
    logic              is_mac;
    logic [IDX_W-1:0]  dst;
    logic [DATA_W-1:0] sum;

    mac_field_decode #(.IDX_W(IDX_W)) u_decode (
        .instr_i (instr_i),
        .is_mac_o(is_mac),
        .dst_o   (dst),
        .sel_a_o (src_a_sel_o),
        .sel_b_o (src_b_sel_o)
    );

    assign acc_sel_o = dst;

    mac_product_sum #(.DATA_W(DATA_W), .OPND_W(OPND_W)) u_math (
        .src_a_i(src_a_i),
        .src_b_i(src_b_i),
        .acc_i  (acc_i),
        .sum_o  (sum)
    );

    mac_commit_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_mac_i (is_mac),
        .dst_i    (dst),
        .sum_i    (sum),
        .hit_o    (hit_o),
        .wr_en_o  (wr_en_o),
        .wr_idx_o (wr_idx_o),
        .wr_data_o(wr_data_o)
    );

    a_r2_foreign_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[6:0] != OPC_MAC) |=> !hit_o);
    a_r9_funct_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[6:0] == OPC_MAC && instr_i[11:7] != 5'd0) |=> wr_en_o);
endmodule

// File: tb/mac_exec_unit_bench.sv
module mac_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0, src_a_i = '0, src_b_i = '0, acc_i = '0;
    logic [4:0]  src_a_sel_o, src_b_sel_o, acc_sel_o, wr_idx_o;
    logic        hit_o, wr_en_o;
    logic [31:0] wr_data_o;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic        hit;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    mac_exec_unit u_mac_exec_unit (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .acc_i(acc_i),
        .src_a_sel_o(src_a_sel_o), .src_b_sel_o(src_b_sel_o), .acc_sel_o(acc_sel_o),
        .hit_o(hit_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
        input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    // driver: apply one word, check read selects, push the expected result
    task automatic issue(input logic [31:0] w, input logic [31:0] a,
        input logic [31:0] b, input logic [31:0] c, input string tag);
        exp_t e;
        logic signed [31:0] xa, xb;
        @(negedge clk);
        instr_i = w; src_a_i = a; src_b_i = b; acc_i = c;
        #1;
        chk({tag, " R10 sel_a"}, 32'(src_a_sel_o), 32'(w[19:15]));
        chk({tag, " R10 sel_b"}, 32'(src_b_sel_o), 32'(w[24:20]));
        chk({tag, " R3 acc_sel"}, 32'(acc_sel_o), 32'(w[11:7]));
        xa = {{16{a[15]}}, a[15:0]};
        xb = {{16{b[15]}}, b[15:0]};
        e.hit  = (w[6:0] == 7'h7F);
        e.we   = e.hit && (w[11:7] != 5'd0);
        e.idx  = e.hit ? w[11:7] : 5'd0;
        e.data = e.hit ? (c + xa * xb) : 32'd0;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // monitor: sample mid high phase, one cycle after the driving edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " hit"},  32'(hit_o),   32'(e.hit));
                chk({e.tag, " we"},   32'(wr_en_o), 32'(e.we));
                chk({e.tag, " idx"},  32'(wr_idx_o), 32'(e.idx));
                chk({e.tag, " data"}, wr_data_o, e.data);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [6:0] MAC = 7'h7F;

    initial begin
        // R1: outputs stay zero in reset even with a recognised word present
        instr_i = 32'h00C5857F; src_a_i = 32'd3; src_b_i = 32'd5; acc_i = 32'd1;
        repeat (3) @(negedge clk);
        chk("R1 hit", 32'(hit_o), 0);
        chk("R1 we", 32'(wr_en_o), 0);
        chk("R1 idx", 32'(wr_idx_o), 0);
        chk("R1 data", wr_data_o, 0);
        instr_i = '0;
        rst_n = 1'b1;
        @(posedge clk); #5;
        chk("R1 first cycle hit", 32'(hit_o), 0);

        // R10 R3 R4: the reference word
        issue(32'h00C5857F, 32'd3, 32'd5, 32'd100, "R3 R4 ref word");
        @(negedge clk); #1;
        chk("R10 ref sel_a", 32'(src_a_sel_o), 32'd11);
        chk("R10 ref sel_b", 32'(src_b_sel_o), 32'd12);
        chk("R10 ref acc_sel", 32'(acc_sel_o), 32'd10);
        // R4 signed extremes
        issue(mk(0, 5'd2, 5'd1, 0, 5'd7, MAC), 32'h0000_8000, 32'h0000_8000, 32'd0, "R4 min*min");
        issue(mk(0, 5'd2, 5'd1, 0, 5'd8, MAC), 32'h0000_7FFF, 32'h0000_8000, 32'd5, "R4 max*min");
        // R5: upper halves are garbage
        issue(mk(0, 5'd4, 5'd3, 0, 5'd9, MAC), 32'hABCD_0002, 32'h1234_FFFF, 32'd10, "R5 upper ignored");
        // R6 wrap
        issue(mk(0, 5'd4, 5'd3, 0, 5'd1, MAC), 32'd1, 32'd1, 32'h7FFF_FFFF, "R6 wrap pos");
        issue(mk(0, 5'd4, 5'd3, 0, 5'd1, MAC), 32'd4, 32'd4, 32'hFFFF_FFF0, "R6 wrap zero");
        // R2 R7: foreign opcodes
        issue(mk(0, 5'd4, 5'd3, 0, 5'd5, 7'h7E), 32'd9, 32'd9, 32'd9, "R2 R7 opc 7E");
        issue(mk(0, 5'd4, 5'd3, 0, 5'd5, 7'h33), 32'd9, 32'd9, 32'd9, "R2 R7 opc 33");
        // R9: function fields set
        issue(mk(7'h55, 5'd6, 5'd7, 3'd5, 5'd31, MAC), 32'hFFFF_FFFD, 32'd7, 32'd1000, "R9 funct set");
        // R8: destination zero
        issue(mk(0, 5'd6, 5'd7, 0, 5'd0, MAC), 32'd6, 32'd7, 32'd1, "R8 rd zero");
        // R11: back-to-back stream crossing every slot transition
        for (int k = 0; k < 12; k++) begin
            logic [6:0] op;
            logic [4:0] rd;
            op = (k % 3 == 2) ? 7'h13 : MAC;
            rd = (k % 4 == 1) ? 5'd0 : 5'(k + 3);
            issue(mk(7'(k), 5'(k), 5'(k + 1), 3'(k), rd, op),
                  32'h5A5A_0000 | 32'(16'(k * 4093 - 20000)),
                  32'hF00F_0000 | 32'(16'(k * 7919 + 1234)),
                  32'(k * 32'h1234_5677), "R11 stream");
        end
        issue(32'h0000_0000, 32'd0, 32'd0, 32'd0, "R7 trailing idle");
        repeat (3) @(posedge clk);
        #6;
        chk("R11 scoreboard drained", 32'(sb.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule